// File: doc/BRIEF.md
# Pin Override and Polarity Stage

This block stands between the board-facing pins and the rest of a reset and
key-handling controller. It carries a configurable number of key and button
signals from their input pins to their output pins, and it also produces two
active-low outputs: one drives a companion controller's reset line and one
drives a flash write-protect line. Each key input can have its polarity flipped
before it reaches the detection logic. Each key output can have its polarity
flipped after the final drive value has been chosen.

Two hardware sources may take over an output. An auto-block engine may force
a key output, and a reset stretcher may pull the reset output low. Software
overrides rank above both. Each software override is gated by two permission
bits: one allows the output to be forced low and the other allows it to be
forced high. A sticky lock freezes the permission bits until the next reset.
The override enable and value registers, and the polarity register, remain
writable after the lock is set.

All pin drives and the polarity-corrected key values are registered, so no
combinational glitch reaches a pad.

Top module: `pin_override_core`

## Requirements
- R1: With no hardware drive and no override in effect, each key output equals its raw input XOR its input-invert bit XOR its output-invert bit. It appears one clock after the input is sampled. The invert write word holds input-invert bits in bits [NK-1:0] and output-invert bits in bits [2*NK-1:NK].
- R2: `key_det_o` equals the raw keys XOR the input-invert bits, one clock after sampling. It is unaffected by overrides and hardware drives.
- R3: A key with its auto-block enable set takes the auto-block value, before output inversion, in place of its polarity-corrected input. While `hw_rst_req_i` is high, the reset output is driven low. Otherwise the reset output is released high.
- R4: An override is applied when the channel's enable bit is set and the permission bit for the requested value is set. Channels are numbered keys 0..NK-1, then reset at NK, then write-protect at NK+1. The allow word holds drive-low permission bits in bits [NK+1:0] and drive-high permission bits in bits [2*NK+3:NK+2].
- R5: An enabled override whose requested value is not permitted has no effect, and the channel keeps its non-override value.
- R6: A permitted override wins over both the auto-block drive and the reset-stretch request.
- R7: After a `lock_set_i` pulse, the lock stays set until reset, and writes to the allow word are ignored until reset. A write in the same cycle as the lock pulse still lands.
- R8: Writes to the override enable and value words take effect whether or not the lock is set.
- R9: The write-protect output has no path from any input. It is 0 unless a permitted override drives it.
- R10: After reset, the reset and write-protect outputs are held low. This happens because their drive-low permission bits and override enables reset to 1, with value 0. All other permission, enable, value and invert bits reset to 0, and the lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_raw_i | input | NK | Raw key and button pin levels |
| hw_key_en_i | input | NK | Auto-block takes over the key output |
| hw_key_val_i | input | NK | Auto-block drive value |
| hw_rst_req_i | input | 1 | Reset-stretch request, pulls the reset output low |
| alw_we_i | input | 1 | Write strobe for the permission word |
| alw_wdata_i | input | 2*(NK+2) | Permission word: drive-low bits low, drive-high bits high |
| lock_set_i | input | 1 | Sets the sticky lock on the permission word |
| oen_we_i | input | 1 | Write strobe for override enables |
| oen_wdata_i | input | NK+2 | Override enable per channel |
| oval_we_i | input | 1 | Write strobe for override values |
| oval_wdata_i | input | NK+2 | Override value per channel |
| inv_we_i | input | 1 | Write strobe for polarity bits |
| inv_wdata_i | input | 2*NK | Input-invert bits low, output-invert bits high |
| key_out_o | output | NK | Registered key output pins |
| rst_out_no | output | 1 | Registered active-low reset output |
| wp_out_no | output | 1 | Registered active-low write-protect output |
| key_det_o | output | NK | Registered polarity-corrected keys for detection logic |

## Verification
The properties treat the hardware drive inputs and the write strobes as synchronous signals that can change on any cycle. They expect reset to be released only between clock edges. The same-cycle case of a lock pulse together with an allow write is allowed, and the lock property looks one cycle back so that this case does not count as a violation. The stimulus changes inputs and strobes only at falling edges and holds each strobe for exactly one rising edge. It then waits two cycles before it compares the outputs, so the register stage on the configuration and the register stage on the pins are both complete before any comparison.

// File: rtl/pov_pkg.sv
package pov_pkg;

    // Channel numbering: keys first, then reset line, then write-protect.
    function automatic int unsigned pov_rst_idx(input int unsigned nk);
        return nk;
    endfunction

    function automatic int unsigned pov_wp_idx(input int unsigned nk);
        return nk + 1;
    endfunction

    // Drive selection applied by one output channel.
    typedef enum logic [1:0] {
        SRC_NATURAL = 2'd0,
        SRC_OVR_LOW = 2'd1,
        SRC_OVR_HIGH = 2'd2
    } pov_src_e;

endpackage

// File: rtl/pov_cfg_regs.sv
module pov_cfg_regs
    import pov_pkg::*;
#(
    parameter int NK = 4,
    localparam int NOUT = NK + 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              alw_we_i,
    input  logic [2*NOUT-1:0] alw_wdata_i,
    input  logic              lock_set_i,
    input  logic              oen_we_i,
    input  logic [NOUT-1:0]   oen_wdata_i,
    input  logic              oval_we_i,
    input  logic [NOUT-1:0]   oval_wdata_i,
    input  logic              inv_we_i,
    input  logic [2*NK-1:0]   inv_wdata_i,
    output logic [NOUT-1:0]   alw0_o,
    output logic [NOUT-1:0]   alw1_o,
    output logic [NOUT-1:0]   oen_o,
    output logic [NOUT-1:0]   oval_o,
    output logic [NK-1:0]     inv_in_o,
    output logic [NK-1:0]     inv_out_o,
    output logic              lock_o
);

    localparam int unsigned RIDX = pov_rst_idx(NK);
    localparam int unsigned WIDX = pov_wp_idx(NK);
    localparam logic [NOUT-1:0] HELD_MASK =
        (NOUT'(1) << RIDX) | (NOUT'(1) << WIDX);

    typedef struct packed {
        logic [NOUT-1:0] alw0;
        logic [NOUT-1:0] alw1;
        logic [NOUT-1:0] oen;
        logic [NOUT-1:0] oval;
        logic [NK-1:0]   inv_in;
        logic [NK-1:0]   inv_out;
        logic            lock;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        alw0:    HELD_MASK,
        alw1:    '0,
        oen:     HELD_MASK,
        oval:    '0,
        inv_in:  '0,
        inv_out: '0,
        lock:    1'b0
    };

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (alw_we_i && !cfg_q.lock) begin
            cfg_d.alw0 = alw_wdata_i[NOUT-1:0];
            cfg_d.alw1 = alw_wdata_i[2*NOUT-1:NOUT];
        end
        if (lock_set_i) begin
            cfg_d.lock = 1'b1;
        end
        if (oen_we_i) begin
            cfg_d.oen = oen_wdata_i;
        end
        if (oval_we_i) begin
            cfg_d.oval = oval_wdata_i;
        end
        if (inv_we_i) begin
            cfg_d.inv_in  = inv_wdata_i[NK-1:0];
            cfg_d.inv_out = inv_wdata_i[2*NK-1:NK];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign alw0_o    = cfg_q.alw0;
    assign alw1_o    = cfg_q.alw1;
    assign oen_o     = cfg_q.oen;
    assign oval_o    = cfg_q.oval;
    assign inv_in_o  = cfg_q.inv_in;
    assign inv_out_o = cfg_q.inv_out;
    assign lock_o    = cfg_q.lock;

endmodule

// File: rtl/pov_chan.sv
module pov_chan
    import pov_pkg::*;
(
    input  logic natural_i,
    input  logic ovr_en_i,
    input  logic ovr_val_i,
    input  logic alw0_i,
    input  logic alw1_i,
    input  logic out_inv_i,
    output logic pin_o
);

    pov_src_e src;
    logic     chosen;

    always_comb begin
        src = SRC_NATURAL;
        if (ovr_en_i) begin
            if (ovr_val_i && alw1_i) begin
                src = SRC_OVR_HIGH;
            end else if (!ovr_val_i && alw0_i) begin
                src = SRC_OVR_LOW;
            end
        end
        unique case (src)
            SRC_OVR_HIGH: chosen = 1'b1;
            SRC_OVR_LOW:  chosen = 1'b0;
            default:      chosen = natural_i;
        endcase
        pin_o = chosen ^ out_inv_i;
    end

endmodule

// File: rtl/pin_override_core.sv
module pin_override_core
    import pov_pkg::*;
#(
    parameter int NK = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NK-1:0]         key_raw_i,
    input  logic [NK-1:0]         hw_key_en_i,
    input  logic [NK-1:0]         hw_key_val_i,
    input  logic                  hw_rst_req_i,
    input  logic                  alw_we_i,
    input  logic [2*(NK+2)-1:0]   alw_wdata_i,
    input  logic                  lock_set_i,
    input  logic                  oen_we_i,
    input  logic [NK+1:0]         oen_wdata_i,
    input  logic                  oval_we_i,
    input  logic [NK+1:0]         oval_wdata_i,
    input  logic                  inv_we_i,
    input  logic [2*NK-1:0]       inv_wdata_i,
    output logic [NK-1:0]         key_out_o,
    output logic                  rst_out_no,
    output logic                  wp_out_no,
    output logic [NK-1:0]         key_det_o
);

    localparam int NOUT = NK + 2;
    localparam int unsigned RIDX = pov_rst_idx(NK);
    localparam int unsigned WIDX = pov_wp_idx(NK);

    logic [NOUT-1:0] cfg_alw0, cfg_alw1, cfg_oen, cfg_oval;
    logic [NK-1:0]   cfg_inv_in, cfg_inv_out;
    logic            cfg_lock;

    pov_cfg_regs #(.NK(NK)) u_cfg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .alw_we_i     (alw_we_i),
        .alw_wdata_i  (alw_wdata_i),
        .lock_set_i   (lock_set_i),
        .oen_we_i     (oen_we_i),
        .oen_wdata_i  (oen_wdata_i),
        .oval_we_i    (oval_we_i),
        .oval_wdata_i (oval_wdata_i),
        .inv_we_i     (inv_we_i),
        .inv_wdata_i  (inv_wdata_i),
        .alw0_o       (cfg_alw0),
        .alw1_o       (cfg_alw1),
        .oen_o        (cfg_oen),
        .oval_o       (cfg_oval),
        .inv_in_o     (cfg_inv_in),
        .inv_out_o    (cfg_inv_out),
        .lock_o       (cfg_lock)
    );

    logic [NK-1:0]   key_pol;
    logic [NOUT-1:0] natural_val;
    logic [NOUT-1:0] out_inv;
    logic [NOUT-1:0] chan_pin;

    assign key_pol = key_raw_i ^ cfg_inv_in;

    for (genvar g = 0; g < NOUT; g++) begin : g_chan
        if (g < NK) begin : g_key
            assign natural_val[g] = hw_key_en_i[g] ? hw_key_val_i[g] : key_pol[g];
            assign out_inv[g]     = cfg_inv_out[g];
        end else if (g == RIDX) begin : g_rst
            assign natural_val[g] = ~hw_rst_req_i;
            assign out_inv[g]     = 1'b0;
        end else begin : g_wp
            assign natural_val[g] = 1'b0;
            assign out_inv[g]     = 1'b0;
        end

        pov_chan u_chan (
            .natural_i (natural_val[g]),
            .ovr_en_i  (cfg_oen[g]),
            .ovr_val_i (cfg_oval[g]),
            .alw0_i    (cfg_alw0[g]),
            .alw1_i    (cfg_alw1[g]),
            .out_inv_i (out_inv[g]),
            .pin_o     (chan_pin[g])
        );
    end

    typedef struct packed {
        logic [NK-1:0] key;
        logic          rst_n;
        logic          wp_n;
        logic [NK-1:0] det;
    } pins_t;

    localparam pins_t PINS_RST = '{
        key:   '1,
        rst_n: 1'b0,
        wp_n:  1'b0,
        det:   '1
    };

    pins_t pins_d, pins_q;

    always_comb begin
        pins_d       = pins_q;
        pins_d.key   = chan_pin[NK-1:0];
        pins_d.rst_n = chan_pin[RIDX];
        pins_d.wp_n  = chan_pin[WIDX];
        pins_d.det   = key_pol;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pins_q <= PINS_RST;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign key_out_o  = pins_q.key;
    assign rst_out_no = pins_q.rst_n;
    assign wp_out_no  = pins_q.wp_n;
    assign key_det_o  = pins_q.det;

endmodule

// File: rtl/pov_chk.sv
module pov_chk #(
    parameter int NK = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [NK-1:0]   key_raw_i,
    input logic            hw_rst_req_i,
    input logic [NK-1:0]   key_out_o,
    input logic            rst_out_no,
    input logic            wp_out_no,
    input logic [NK-1:0]   key_det_o,
    input logic [NK+1:0]   cfg_alw0,
    input logic [NK+1:0]   cfg_alw1,
    input logic [NK+1:0]   cfg_oen,
    input logic [NK+1:0]   cfg_oval,
    input logic [NK-1:0]   cfg_inv_in,
    input logic [NK-1:0]   cfg_inv_out,
    input logic            cfg_lock
);

    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_lock |=> cfg_lock); // R7

    AST_ALLOW_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_lock && $past(cfg_lock)) |-> ($stable(cfg_alw0) && $stable(cfg_alw1))); // R7

    AST_DET_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> key_det_o == $past(key_raw_i ^ cfg_inv_in)); // R2

    AST_WP_NO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_oen[NK+1] |=> !wp_out_no); // R9

    AST_RST_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_rst_req_i && !cfg_oen[NK]) |=> !rst_out_no); // R3

    AST_RST_OVR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_oen[NK] && cfg_oval[NK] && cfg_alw1[NK]) |=> rst_out_no); // R6

    for (genvar k = 0; k < NK; k++) begin : g_key_chk
        AST_KEY_OVR_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_oen[k] && cfg_oval[k] && cfg_alw1[k])
            |=> key_out_o[k] == !$past(cfg_inv_out[k])); // R4
        AST_KEY_OVR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_oen[k] && !cfg_oval[k] && cfg_alw0[k])
            |=> key_out_o[k] == $past(cfg_inv_out[k])); // R4
    end

endmodule

bind pin_override_core pov_chk #(.NK(NK)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .key_raw_i    (key_raw_i),
    .hw_rst_req_i (hw_rst_req_i),
    .key_out_o    (key_out_o),
    .rst_out_no   (rst_out_no),
    .wp_out_no    (wp_out_no),
    .key_det_o    (key_det_o),
    .cfg_alw0     (cfg_alw0),
    .cfg_alw1     (cfg_alw1),
    .cfg_oen      (cfg_oen),
    .cfg_oval     (cfg_oval),
    .cfg_inv_in   (cfg_inv_in),
    .cfg_inv_out  (cfg_inv_out),
    .cfg_lock     (cfg_lock)
);

// File: tb/sim_pin_override_core.sv
`timescale 1ns/1ps
module sim_pin_override_core;

    localparam int NK = 4;
    localparam int NOUT = NK + 2;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic [NK-1:0]     key_raw_i = '1;
    logic [NK-1:0]     hw_key_en_i = '0;
    logic [NK-1:0]     hw_key_val_i = '0;
    logic              hw_rst_req_i = 1'b0;
    logic              alw_we_i = 1'b0;
    logic [2*NOUT-1:0] alw_wdata_i = '0;
    logic              lock_set_i = 1'b0;
    logic              oen_we_i = 1'b0;
    logic [NOUT-1:0]   oen_wdata_i = '0;
    logic              oval_we_i = 1'b0;
    logic [NOUT-1:0]   oval_wdata_i = '0;
    logic              inv_we_i = 1'b0;
    logic [2*NK-1:0]   inv_wdata_i = '0;
    logic [NK-1:0]     key_out_o;
    logic              rst_out_no;
    logic              wp_out_no;
    logic [NK-1:0]     key_det_o;

    always #2.5 clk = ~clk;

    pin_override_core #(.NK(NK)) u0 (
        .clk_i(clk), .rst_ni(rst_ni), .key_raw_i(key_raw_i),
        .hw_key_en_i(hw_key_en_i), .hw_key_val_i(hw_key_val_i),
        .hw_rst_req_i(hw_rst_req_i), .alw_we_i(alw_we_i), .alw_wdata_i(alw_wdata_i),
        .lock_set_i(lock_set_i), .oen_we_i(oen_we_i), .oen_wdata_i(oen_wdata_i),
        .oval_we_i(oval_we_i), .oval_wdata_i(oval_wdata_i), .inv_we_i(inv_we_i),
        .inv_wdata_i(inv_wdata_i), .key_out_o(key_out_o), .rst_out_no(rst_out_no),
        .wp_out_no(wp_out_no), .key_det_o(key_det_o)
    );

    // Bench-side view of the configuration, kept from the requirements.
    logic [NOUT-1:0] m_alw0, m_alw1, m_oen, m_oval;
    logic [NK-1:0]   m_inv_in, m_inv_out;
    logic            m_lock;

    typedef struct {
        logic [NK-1:0] key;
        logic          rst_n;
        logic          wp_n;
        logic [NK-1:0] det;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    task automatic model_reset();
        m_alw0 = '0; m_alw0[NK] = 1'b1; m_alw0[NK+1] = 1'b1;   // R10
        m_oen  = '0; m_oen[NK]  = 1'b1; m_oen[NK+1]  = 1'b1;
        m_alw1 = '0; m_oval = '0; m_inv_in = '0; m_inv_out = '0; m_lock = 1'b0;
    endtask

    function automatic logic pick(input logic nat, input int ch);
        if (m_oen[ch] && m_oval[ch] && m_alw1[ch]) return 1'b1;   // R4, R6
        if (m_oen[ch] && !m_oval[ch] && m_alw0[ch]) return 1'b0;
        return nat;                                              // R5
    endfunction

    task automatic expect_now(input string tag);
        exp_t e;
        for (int i = 0; i < NK; i++) begin
            logic nat;
            nat = hw_key_en_i[i] ? hw_key_val_i[i] : (key_raw_i[i] ^ m_inv_in[i]); // R3, R1
            e.key[i] = pick(nat, i) ^ m_inv_out[i];
        end
        e.rst_n = pick(~hw_rst_req_i, NK);
        e.wp_n  = pick(1'b0, NK + 1);                                   // R9
        e.det   = key_raw_i ^ m_inv_in;                                 // R2
        e.tag   = tag;
        @(negedge clk);
        @(negedge clk);
        exp_q.push_back(e);
        #0.5;
    endtask

    task automatic wr_alw(input logic [2*NOUT-1:0] d);
        @(negedge clk); alw_we_i = 1'b1; alw_wdata_i = d;
        @(negedge clk); alw_we_i = 1'b0;
        if (!m_lock) begin m_alw0 = d[NOUT-1:0]; m_alw1 = d[2*NOUT-1:NOUT]; end
    endtask

    task automatic wr_oen(input logic [NOUT-1:0] d);
        @(negedge clk); oen_we_i = 1'b1; oen_wdata_i = d;
        @(negedge clk); oen_we_i = 1'b0; m_oen = d;
    endtask

    task automatic wr_oval(input logic [NOUT-1:0] d);
        @(negedge clk); oval_we_i = 1'b1; oval_wdata_i = d;
        @(negedge clk); oval_we_i = 1'b0; m_oval = d;
    endtask

    task automatic wr_inv(input logic [2*NK-1:0] d);
        @(negedge clk); inv_we_i = 1'b1; inv_wdata_i = d;
        @(negedge clk); inv_we_i = 1'b0;
        m_inv_in = d[NK-1:0]; m_inv_out = d[2*NK-1:NK];
    endtask

    task automatic do_lock();
        @(negedge clk); lock_set_i = 1'b1;
        @(negedge clk); lock_set_i = 1'b0; m_lock = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_ni = 1'b0;
        model_reset();
        @(negedge clk); @(negedge clk); rst_ni = 1'b1;
    endtask

    // Monitor: compares each queued expectation as soon as it appears.
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            n_checks++;
            if (key_out_o !== e.key || rst_out_no !== e.rst_n ||
                wp_out_no !== e.wp_n || key_det_o !== e.det) begin
                n_errors++;
                $display("FAIL %s: got key=%b rst=%b wp=%b det=%b expected key=%b rst=%b wp=%b det=%b",
                         e.tag, key_out_o, rst_out_no, wp_out_no, key_det_o,
                         e.key, e.rst_n, e.wp_n, e.det);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        key_raw_i = 4'b1010;
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        expect_now("R10 reset defaults hold reset and write-protect low");

        key_raw_i = 4'b0101;
        expect_now("R1 plain passthrough");

        wr_oen('0);
        expect_now("R10 reset line released once enable cleared");

        wr_oen(6'b100000); wr_oval(6'b100000);
        expect_now("R5 write-protect high override not permitted");

        wr_inv(8'b0101_0011); key_raw_i = 4'b0110;
        expect_now("R1 R2 input and output inversion");

        wr_inv('0); hw_key_en_i = 4'b1000; hw_key_val_i = 4'b0000; key_raw_i = 4'b1111;
        expect_now("R3 auto-block drive on key 3");

        wr_oen('0); wr_oval('0); hw_rst_req_i = 1'b1;
        expect_now("R3 reset stretch request pulls reset low");

        wr_alw({6'b101111, 6'b001111}); wr_oen(6'b000010);
        expect_now("R4 key 1 forced low");

        wr_oen(6'b000100); wr_oval(6'b000100);
        wr_alw({6'b100011, 6'b001111});
        expect_now("R5 key 2 high override without permission");

        hw_key_en_i = 4'b0010; hw_key_val_i = 4'b0010;
        wr_oen(6'b010010); wr_oval(6'b010000);
        wr_alw({6'b110011, 6'b001111});
        expect_now("R6 overrides beat auto-block and reset stretch");

        do_lock();
        wr_alw('0);
        expect_now("R7 allow write ignored after lock");

        wr_oval(6'b010010);
        expect_now("R8 value write after lock drives key 1 high");

        wr_oen(6'b100000); wr_oval(6'b100000); hw_rst_req_i = 1'b0;
        expect_now("R8 R9 write-protect released by permitted override");

        wr_oen('0); key_raw_i = 4'b0000;
        expect_now("R9 write-protect low without override");

        hw_key_en_i = '0;
        do_reset();
        expect_now("R10 defaults restored by reset");

        wr_alw({6'b000001, 6'b000000}); wr_oen(6'b000001); wr_oval(6'b000001);
        expect_now("R7 lock cleared by reset, allow write lands");

        @(negedge clk); @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule